// File: doc/BRIEF.md
# Lane-Banked Byte/Word Data Memory

This block is a small data store for a simple processor datapath. It holds 128 words of 32 bits and accepts either whole-word or single-byte accesses. Storage is split into four independent byte-wide banks, one per byte lane. All four banks share one row index, so a word access touches the same row in every bank, and a byte access touches the row in exactly one bank.

Reads are combinational: while the read strobe is high, the output follows the addressed row with no clock involved. Writes commit on the falling clock edge. A datapath that settles its address and data after the rising edge can therefore write in the second half of the same cycle. Address bits above the row field are ignored, so the storage repeats every 512 bytes of address space.

Top module: `banked_dmem`

## Requirements
- R1: With byteMode low, a write stores all 32 bits of wrData at row addr[8:2], and a word read of that row returns those 32 bits unchanged. Word accesses use addr[1:0] = 00.
- R2: The contents change only on a falling clock edge while memWrite is high. A falling edge with memWrite low leaves every stored bit unchanged.
- R3: A word write enables all four lanes together.
- R4: With byteMode high, a write stores wrData[7:0] into lane addr[1:0] only and leaves the other three lanes unchanged. Lanes are little-endian: lane 0 is word bits 7:0, lane 1 is bits 15:8, lane 2 is bits 23:16 and lane 3 is bits 31:24.
- R5: With byteMode high and memRead high, rdData[7:0] holds lane addr[1:0] of row addr[8:2], and rdData[31:8] is zero.
- R6: rdData is all zeros whenever memRead is low.
- R7: Address bits 31:9 are ignored. Addresses that differ only in those bits reach the same storage.
- R8: Reads are combinational. If a read and a write to the same row overlap in one cycle, rdData shows the old contents before the falling edge and the new contents right after it, with no rising edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its falling edge |
| memWrite | input | 1 | Write strobe |
| memRead | input | 1 | Read strobe; when low, rdData is zero |
| byteMode | input | 1 | 1 = single-byte access, 0 = full-word access |
| addr | input | 32 | Byte address; bits 8:2 select the row, bits 1:0 select the lane in byte mode |
| wrData | input | 32 | Write data; only bits 7:0 are used in byte mode |
| rdData | output | 32 | Read data, zero-extended in byte mode |

## Verification
The hardest case to reach from the ports is the overlap of a read and a write to one row. Here the combinational read must show the old word in the first half of the cycle and the new word as soon as the falling edge passes. The stimulus raises both strobes just after a rising edge and samples rdData twice: once before the falling edge and once just after it. Lane isolation is the other subtle case. A full sweep writes every one of the 512 byte positions one at a time, then reads back every byte and every word against an arithmetic model. A single lane-decode or steering error therefore shows up as a corrupted neighbour somewhere in the sweep.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = $clog2(LANES);
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;

  typedef struct packed {
    logic [LANES-1:0]  laneWe;
    logic              rdEn;
    logic              byteMode;
    logic [LANE_W-1:0] laneSel;
  } dmemStrobe_t;
endpackage

// File: rtl/dmem_byte_bank.sv
module dmem_byte_bank #(
  parameter int DEPTH = 128,
  localparam int ROW_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wrByte,
  output logic [7:0]       rdByte
);
  logic [7:0] cells [DEPTH];

  always_ff @(negedge clk) begin
    if (we) cells[row] <= wrByte;
  end

  assign rdByte = cells[row];
endmodule

// File: rtl/dmem_ctrl.sv
module dmem_ctrl
  import dmem_pkg::*;
(
  input  logic              clk,
  input  logic              memWrite,
  input  logic              memRead,
  input  logic              byteMode,
  input  logic [LANE_W-1:0] laneAddr,
  output dmemStrobe_t       strobe
);
  always_comb begin
    strobe.rdEn     = memRead;
    strobe.byteMode = byteMode;
    strobe.laneSel  = laneAddr;
    for (int i = 0; i < LANES; i++) begin
      strobe.laneWe[i] = memWrite && (!byteMode || (laneAddr == LANE_W'(i)));
    end
  end

  // Lane enable checks, sampled at the commit edge
  always @(negedge clk) begin
    if (memWrite && !byteMode)
      a_r3_word_all_lanes: assert (&strobe.laneWe)
        else $error("word write must enable every lane");
    if (memWrite && byteMode)
      a_r4_byte_one_lane: assert ($countones(strobe.laneWe) == 1)
        else $error("byte write must enable exactly one lane");
    if (!memWrite)
      a_r2_idle_no_lane: assert (strobe.laneWe == '0)
        else $error("lane enabled without write strobe");
  end
endmodule

// File: rtl/dmem_datapath.sv
module dmem_datapath
  import dmem_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int ROW_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  dmemStrobe_t       strobe,
  input  logic [ROW_W-1:0]  row,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);
  logic [BYTE_W-1:0] laneRd [LANES];
  logic [BYTE_W-1:0] laneWr [LANES];
  logic [WORD_W-1:0] wordRd;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneWr[g] = strobe.byteMode ? wrData[BYTE_W-1:0]
                                       : wrData[g*BYTE_W +: BYTE_W];
    assign wordRd[g*BYTE_W +: BYTE_W] = laneRd[g];

    dmem_byte_bank #(.DEPTH(DEPTH)) u_bank (
      .clk    (clk),
      .we     (strobe.laneWe[g]),
      .row    (row),
      .wrByte (laneWr[g]),
      .rdByte (laneRd[g])
    );
  end

  always_comb begin
    if (!strobe.rdEn)
      rdData = '0;
    else if (strobe.byteMode)
      rdData = {{(WORD_W-BYTE_W){1'b0}}, laneRd[strobe.laneSel]};
    else
      rdData = wordRd;
  end
endmodule

// File: rtl/banked_dmem.sv
module banked_dmem
  import dmem_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int ADDR_W = 32,
  localparam int ROW_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              memWrite,
  input  logic              memRead,
  input  logic              byteMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);
  dmemStrobe_t strobe;
  logic [ROW_W-1:0] row;

  assign row = addr[LANE_W +: ROW_W];

  dmem_ctrl u_ctrl (
    .clk      (clk),
    .memWrite (memWrite),
    .memRead  (memRead),
    .byteMode (byteMode),
    .laneAddr (addr[LANE_W-1:0]),
    .strobe   (strobe)
  );

  dmem_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk    (clk),
    .strobe (strobe),
    .row    (row),
    .wrData (wrData),
    .rdData (rdData)
  );

  // Port-level read-path checks
  always @(posedge clk) begin
    if (!memRead)
      a_r6_idle_zero: assert (rdData == '0)
        else $error("read data not zero while read strobe low");
    if (memRead && byteMode)
      a_r5_upper_zero: assert (rdData[WORD_W-1:BYTE_W] == '0)
        else $error("byte read not zero-extended");
  end
endmodule

// File: tb/banked_dmem_bench.sv
module banked_dmem_bench;
  logic        clk = 1'b0;
  logic        memWrite = 1'b0;
  logic        memRead = 1'b0;
  logic        byteMode = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [31:0] model [128];

  always #4 clk = ~clk;

  banked_dmem u_banked_dmem (
    .clk(clk), .memWrite(memWrite), .memRead(memRead), .byteMode(byteMode),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [31:0] wordPat(int i);
    return (32'h9E3779B9 * (i + 1)) ^ (i << 16);
  endfunction

  function automatic logic [7:0] bytePat(int b);
    return 8'((b * 37 + 11) & 255);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h (addr %h)", req, got, exp, addr);
    end
  endtask

  task automatic doWrite(logic [31:0] a, logic [31:0] d, logic bm);
    @(posedge clk); #1;
    addr = a; wrData = d; byteMode = bm; memWrite = 1'b1; memRead = 1'b0;
    @(negedge clk); #1;
    memWrite = 1'b0;
  endtask

  task automatic doRead(logic [31:0] a, logic bm);
    memWrite = 1'b0; memRead = 1'b1; addr = a; byteMode = bm;
    #1;
  endtask

  initial begin
    #1;
    check("R6", rdData, 32'h0);

    // R1/R3: word sweep
    for (int i = 0; i < 128; i++) begin
      doWrite(32'(i * 4), wordPat(i), 1'b0);
      model[i] = wordPat(i);
    end
    for (int i = 0; i < 128; i++) begin
      doRead(32'(i * 4), 1'b0);
      check("R1", rdData, model[i]);
    end

    // R2: falling edges without write strobe change nothing
    @(posedge clk); #1;
    memRead = 1'b0; memWrite = 1'b0; addr = 32'h20; wrData = 32'hDEADBEEF;
    @(negedge clk); @(negedge clk); #1;
    doRead(32'h20, 1'b0);
    check("R2", rdData, model[8]);

    // R6: read strobe low gives zeros
    memRead = 1'b0; addr = 32'h40; #1;
    check("R6", rdData, 32'h0);

    // R4: every byte position written alone
    for (int b = 0; b < 512; b++) begin
      doWrite(32'(b) | 32'hFFFFFF00 & 32'h0, {24'hABCDEF, bytePat(b)}, 1'b1);
      model[b >> 2][8 * (b & 3) +: 8] = bytePat(b);
      if ((b & 3) == 1) begin
        doRead(32'(b & ~3), 1'b0);
        check("R4", rdData, model[b >> 2]);
      end
    end

    // R5: byte reads, zero-extended
    for (int b = 0; b < 512; b++) begin
      doRead(32'(b), 1'b1);
      check("R5", rdData, {24'h0, model[b >> 2][8 * (b & 3) +: 8]});
    end
    for (int i = 0; i < 128; i++) begin
      doRead(32'(i * 4), 1'b0);
      check("R4", rdData, model[i]);
    end

    // R7: high address bits alias
    for (int k = 1; k < 8; k++) begin
      int row = (k * 19) & 127;
      doWrite((32'(k) << 9) | (32'(k) << 24) | 32'(row * 4), 32'h5A000000 + 32'(k), 1'b0);
      model[row] = 32'h5A000000 + 32'(k);
      doRead(32'(row * 4), 1'b0);
      check("R7", rdData, model[row]);
      doRead(32'hFFFFFE00 | 32'(row * 4 + 3), 1'b1);
      check("R7", rdData, {24'h0, model[row][31:24]});
    end

    // R8: overlapping read and write on one row
    for (int k = 0; k < 4; k++) begin
      int row = 50 + k;
      logic [31:0] nv;
      nv = ~model[row] ^ 32'(k);
      @(posedge clk); #1;
      addr = 32'(row * 4); wrData = nv; byteMode = 1'b0;
      memWrite = 1'b1; memRead = 1'b1; #1;
      check("R8", rdData, model[row]);
      @(negedge clk); #1;
      model[row] = nv;
      check("R8", rdData, nv);
      memWrite = 1'b0;
    end
    memRead = 1'b0; #1;
    check("R6", rdData, 32'h0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule